// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Digit-Select Readback

This block keeps seconds, minutes, hours (24-hour form), day of week, day of month, month and a two-digit year as packed BCD fields. A one-cycle enable pulse, asserted once per second by the surrounding logic, advances the seconds. Carries ripple through the fields in the same cycle, following a fixed month-length table.

Software reaches the block through two byte-wide ports on a one-bit address. A command-port write holds a 4-bit digit selector and a 4-bit flag nibble. A data-port read returns the selected BCD digit in the low nibble. The hold flag freezes the count so a multi-digit read is coherent. A second that arrives while the hold flag is set is kept and applied once the flag clears. The write flag lets a data-port write load one digit.

Top module: `rtc_nibble_clock`

## Requirements
- R1: A command write (bus_addr=0) stores bus_wdata[3:0] as the digit selector and bus_wdata[7:4] as flags: bit 6 holds the count, bit 5 enables digit loads, bit 4 is a stored read flag. A command-port read returns 8'hFF.
- R2: After reset the clock reads 00:00:00, day of week 0, date 01, month 01, year 00, and the selector and flags are zero.
- R3: A data-port read (bus_addr=1) returns {4'h0, digit}. Selectors 0..12 pick these digits: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day of week, 7 date units, 8 date tens, 9 month units, 10 month tens, 11 year units, 12 year tens.
- R4: A data read with selector 5 returns the hours-tens value in bits 1:0 with bit 3 set (24-hour indication) and all other bits clear.
- R5: A data read with selector 13, 14 or 15 returns 8'h00.
- R6: A second advances the seconds in BCD. Seconds 59 wrap to 00 and step the minutes. Minutes 59 wrap and step the hours. Hours 23 wrap to 00 and step both the day of week (0..6, 6 wraps to 0) and the date.
- R7: The last date of a month is 28 for month 02, 30 for months 04, 06, 09 and 11, and 31 otherwise. Passing the last date gives date 01 and steps the month. Month 12 wraps to 01 and steps the year. Year 99 wraps to 00.
- R8: While the hold flag is set no field changes on a tick. Any number of ticks during hold produce exactly one advance, on the first cycle with hold clear.
- R9: With the write flag set, a data write loads bus_wdata[3:0] into the selected digit. For selector 5 only bits 1:0 are loaded. A data write without the write flag, or with a selector above 12, changes nothing.
- R10: A tick in the same cycle as a digit load is deferred and applied in the next cycle when hold is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_addr | input | 1 | 0 selects the command port, 1 the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed port, combinational |

## Verification
Reads are combinational, so bus_rdata is due in the same cycle as a change of bus_addr or of the stored selector. A command or digit write is visible after the edge that samples it. A tick that is not held off changes the fields at the edge that samples it. A deferred tick lands one edge after hold clears, or one edge after the load it collided with. The bench drives inputs on falling edges and samples one nanosecond after a falling edge. It always lets at least one further rising edge pass after a stimulus before it reads. The expected digits come from an integer time model that the bench advances by ordinary arithmetic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W     = 8;
  localparam int SEL_W      = 4;
  localparam int NIB_W      = 4;
  localparam int FLAG_W     = DATA_W - SEL_W;
  localparam int NUM_DIGITS = 13;
  localparam logic [SEL_W-1:0] LAST_DIGIT = SEL_W'(NUM_DIGITS - 1);
  // flag positions within the stored flag nibble
  localparam int FLAG_HOLD = 2;
  localparam int FLAG_LOAD = 1;
  localparam int FLAG_READ = 0;

  typedef enum logic [SEL_W-1:0] {
    DG_SEC_U = 4'd0,  DG_SEC_T = 4'd1,  DG_MIN_U = 4'd2,  DG_MIN_T = 4'd3,
    DG_HR_U  = 4'd4,  DG_HR_T  = 4'd5,  DG_WDAY  = 4'd6,  DG_DAY_U = 4'd7,
    DG_DAY_T = 4'd8,  DG_MON_U = 4'd9,  DG_MON_T = 4'd10, DG_YR_U  = 4'd11,
    DG_YR_T  = 4'd12
  } digit_e;

  typedef struct packed {
    logic [7:0]       sec;
    logic [7:0]       min;
    logic [7:0]       hour;
    logic [NIB_W-1:0] wday;
    logic [7:0]       mday;
    logic [7:0]       mon;
    logic [7:0]       year;
  } cal_t;

  // One BCD step; any value at or above top returns bottom.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] bottom);
    logic [7:0] r;
    if (v >= top)             r = bottom;
    else if (v[3:0] >= 4'd9)  r = {v[7:4] + 4'd1, 4'd0};
    else                      r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_cmd_reg.sv
module rtc_cmd_reg
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [SEL_W-1:0]  sel_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [SEL_W-1:0]  sel_q,   sel_d;
  logic [FLAG_W-1:0] flags_q, flags_d;

  always_comb begin
    sel_d   = sel_q;
    flags_d = flags_q;
    if (cmd_we) begin
      sel_d   = cmd_wdata[SEL_W-1:0];
      flags_d = cmd_wdata[DATA_W-1:SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      flags_q <= '0;
    end else begin
      sel_q   <= sel_d;
      flags_q <= flags_d;
    end
  end

  assign sel_o   = sel_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic load_busy,
  output logic adv_o,
  output logic pend_o
);
  logic pend_q, pend_d, adv;

  always_comb begin
    adv    = (tick | pend_q) & ~hold & ~load_busy;
    pend_d = (tick | pend_q) & ~adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign adv_o  = adv;
  assign pend_o = pend_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load_en,
  input  logic [SEL_W-1:0] load_sel,
  input  logic [NIB_W-1:0] load_nib,
  output cal_t             cal_o
);
  cal_t cal_q, cal_d;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

  always_comb begin
    cal_d    = cal_q;
    sec_wrap = cal_q.sec  >= 8'h59;
    min_wrap = cal_q.min  >= 8'h59;
    hr_wrap  = cal_q.hour >= 8'h23;
    day_wrap = cal_q.mday >= month_last(cal_q.mon);
    mon_wrap = cal_q.mon  >= 8'h12;
    if (load_en) begin
      case (digit_e'(load_sel))
        DG_SEC_U: cal_d.sec[3:0]  = load_nib;
        DG_SEC_T: cal_d.sec[7:4]  = load_nib;
        DG_MIN_U: cal_d.min[3:0]  = load_nib;
        DG_MIN_T: cal_d.min[7:4]  = load_nib;
        DG_HR_U:  cal_d.hour[3:0] = load_nib;
        DG_HR_T:  cal_d.hour[7:4] = {2'b00, load_nib[1:0]};
        DG_WDAY:  cal_d.wday      = load_nib;
        DG_DAY_U: cal_d.mday[3:0] = load_nib;
        DG_DAY_T: cal_d.mday[7:4] = load_nib;
        DG_MON_U: cal_d.mon[3:0]  = load_nib;
        DG_MON_T: cal_d.mon[7:4]  = load_nib;
        DG_YR_U:  cal_d.year[3:0] = load_nib;
        DG_YR_T:  cal_d.year[7:4] = load_nib;
        default:  ;
      endcase
    end else if (adv) begin
      cal_d.sec = bcd_step(cal_q.sec, 8'h59, 8'h00);
      if (sec_wrap) begin
        cal_d.min = bcd_step(cal_q.min, 8'h59, 8'h00);
        if (min_wrap) begin
          cal_d.hour = bcd_step(cal_q.hour, 8'h23, 8'h00);
          if (hr_wrap) begin
            cal_d.wday = (cal_q.wday >= NIB_W'(6)) ? '0 : cal_q.wday + NIB_W'(1);
            cal_d.mday = bcd_step(cal_q.mday, month_last(cal_q.mon), 8'h01);
            if (day_wrap) begin
              cal_d.mon = bcd_step(cal_q.mon, 8'h12, 8'h01);
              if (mon_wrap) cal_d.year = bcd_step(cal_q.year, 8'h99, 8'h00);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q.sec  <= 8'h00;
      cal_q.min  <= 8'h00;
      cal_q.hour <= 8'h00;
      cal_q.wday <= '0;
      cal_q.mday <= 8'h01;
      cal_q.mon  <= 8'h01;
      cal_q.year <= 8'h00;
    end else begin
      cal_q <= cal_d;
    end
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/rtc_digit_mux.sv
module rtc_digit_mux
  import rtc_pkg::*;
(
  input  cal_t              cal,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] digit_o
);
  logic [NIB_W-1:0] nib;

  always_comb begin
    case (digit_e'(sel))
      DG_SEC_U: nib = cal.sec[3:0];
      DG_SEC_T: nib = cal.sec[7:4];
      DG_MIN_U: nib = cal.min[3:0];
      DG_MIN_T: nib = cal.min[7:4];
      DG_HR_U:  nib = cal.hour[3:0];
      DG_HR_T:  nib = {2'b10, cal.hour[5:4]};
      DG_WDAY:  nib = cal.wday;
      DG_DAY_U: nib = cal.mday[3:0];
      DG_DAY_T: nib = cal.mday[7:4];
      DG_MON_U: nib = cal.mon[3:0];
      DG_MON_T: nib = cal.mon[7:4];
      DG_YR_U:  nib = cal.year[3:0];
      DG_YR_T:  nib = cal.year[7:4];
      default:  nib = '0;
    endcase
    digit_o = {{(DATA_W-NIB_W){1'b0}}, nib};
  end
endmodule

// File: rtl/rtc_nibble_clock.sv
module rtc_nibble_clock
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              rst_meta_q, rst_int_n;
  logic [SEL_W-1:0]  sel_q;
  logic [FLAG_W-1:0] flags_q;
  logic              hold_q, loadflag_q, load_en, adv, pend_q;
  cal_t              cal_q;
  logic [DATA_W-1:0] digit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  rtc_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_we(bus_wr & ~bus_addr), .cmd_wdata(bus_wdata),
    .sel_o(sel_q), .flags_o(flags_q)
  );

  assign hold_q     = flags_q[FLAG_HOLD];
  assign loadflag_q = flags_q[FLAG_LOAD];
  assign load_en    = bus_wr & bus_addr & loadflag_q & (sel_q <= LAST_DIGIT);

  rtc_tick_gate u_gate (
    .clk(clk), .rst_n(rst_int_n),
    .tick(tick_1s), .hold(hold_q), .load_busy(load_en),
    .adv_o(adv), .pend_o(pend_q)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_int_n),
    .adv(adv), .load_en(load_en), .load_sel(sel_q),
    .load_nib(bus_wdata[NIB_W-1:0]), .cal_o(cal_q)
  );

  rtc_digit_mux u_mux (.cal(cal_q), .sel(sel_q), .digit_o(digit));

  assign bus_rdata = bus_addr ? digit : {DATA_W{1'b1}};
endmodule

// File: rtl/rtc_nibble_clock_chk.sv
module rtc_nibble_clock_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SEL_W-1:0]  sel,
  input logic [FLAG_W-1:0] flags,
  input logic              load_en,
  input logic              adv,
  input logic              pend,
  input cal_t              cal
);
  a_r1_cmd_read_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata == 8'hFF);

  a_r1_cmd_fields_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> (sel == $past(bus_wdata[SEL_W-1:0]) &&
                               flags == $past(bus_wdata[DATA_W-1:SEL_W])));

  a_r4_hours_tens_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && sel == 4'd5) |-> (bus_rdata[7:2] == 6'b000010));

  a_r5_high_select_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && sel > LAST_DIGIT) |-> bus_rdata == 8'h00);

  a_r6_units_valid: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cal.sec[3:0] <= 4'd9);

  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLAG_HOLD] && !load_en) |=> $stable(cal));

  a_r8_deferred_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FLAG_HOLD] && pend && !load_en) |=> cal.sec != $past(cal.sec));
endmodule

bind rtc_nibble_clock rtc_nibble_clock_chk chk_i (
  .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel(sel_q), .flags(flags_q),
  .load_en(load_en), .adv(adv), .pend(pend_q), .cal(cal_q)
);

// File: tb/rtc_nibble_clock_tb_top.sv
module rtc_nibble_clock_tb_top;
  logic       clk, rst_n, tick_1s, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int checks, failures;
  int m_sec, m_min, m_hr, m_dow, m_day, m_mon, m_yr;
  logic [7:0] cur_flags;

  rtc_nibble_clock dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int mlen(input int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 6) ? 0 : m_dow + 1;
          m_day++;
          if (m_day > mlen(m_mon)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1;
              m_yr = (m_yr == 99) ? 0 : m_yr + 1;
            end
          end
        end
      end
    end
  endtask

  function automatic logic [7:0] exp_digit(input int d);
    case (d)
      0:  return 8'(m_sec % 10);
      1:  return 8'(m_sec / 10);
      2:  return 8'(m_min % 10);
      3:  return 8'(m_min / 10);
      4:  return 8'(m_hr % 10);
      5:  return 8'h08 | 8'(m_hr / 10);
      6:  return 8'(m_dow);
      7:  return 8'(m_day % 10);
      8:  return 8'(m_day / 10);
      9:  return 8'(m_mon % 10);
      10: return 8'(m_mon / 10);
      11: return 8'(m_yr % 10);
      12: return 8'(m_yr / 10);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] v);
    @(negedge clk); bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic dwr(input logic [7:0] v);
    @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
  endtask

  task automatic check_digit(input int d, input string req);
    cmd(cur_flags | 8'(d));
    bus_addr = 1'b1;
    #1;
    check(req, bus_rdata, exp_digit(d));
  endtask

  task automatic check_all(input string req);
    for (int d = 0; d < 13; d++) check_digit(d, req);
  endtask

  task automatic load_digit(input int d, input int v);
    cmd(8'h20 | 8'(d));
    dwr(8'(v));
  endtask

  task automatic set_time(input int h, input int mi, input int s, input int w,
                          input int dy, input int mo, input int y);
    m_hr = h; m_min = mi; m_sec = s; m_dow = w; m_day = dy; m_mon = mo; m_yr = y;
    for (int d = 0; d < 13; d++) load_digit(d, (d == 5) ? (h / 10) : int'(exp_digit(d)));
    cmd(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; cur_flags = 8'h00;
    rst_n = 1'b0; tick_1s = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_day = 1; m_mon = 1; m_yr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state, R1 command read
    bus_addr = 1'b1; #1;
    check("R2 selector zero reads seconds units", bus_rdata, 8'h00);
    bus_addr = 1'b0; #1;
    check("R1 command read", bus_rdata, 8'hFF);
    check_all("R2");

    // R6/R3: sweep over an hour and a minute
    for (int i = 1; i <= 3661; i++) begin
      pulse_tick();
      model_advance();
      if (i % 61 == 0) check_all("R6");
    end
    check_all("R3");

    // R6: day roll with day-of-week wrap
    set_time(23, 59, 59, 6, 15, 6, 7);
    pulse_tick(); model_advance();
    check_all("R6 day roll");

    // R7: each month end, December into a year wrap
    for (int m = 1; m <= 12; m++) begin
      set_time(23, 59, 59, 3, mlen(m), m, (m == 12) ? 99 : 42);
      pulse_tick(); model_advance();
      check_all("R7");
    end

    // R4: an hour in the twenties keeps the flag with tens 2
    set_time(21, 10, 5, 2, 9, 3, 50);
    check_digit(5, "R4");

    // R8: hold collapses several ticks into one
    cur_flags = 8'h40;
    cmd(8'h40);
    for (int i = 0; i < 5; i++) pulse_tick();
    check_digit(0, "R8 frozen");
    check_digit(1, "R8 frozen");
    cur_flags = 8'h00;
    cmd(8'h00);
    model_advance();
    check_all("R8 one deferred tick");

    // R9: data write without load flag does nothing
    cmd(8'h00);
    dwr(8'h07);
    check_all("R9 no load flag");

    // R9 and R5: selectors above 12
    for (int d = 13; d < 16; d++) begin
      cmd(8'h20 | 8'(d));
      dwr(8'h03);
      bus_addr = 1'b1; #1;
      check("R5 high selector", bus_rdata, 8'h00);
    end
    check_all("R9 high selector write ignored");

    // R9: hours tens loads only two bits
    cmd(8'h25);
    dwr(8'h0D);
    m_hr = 10 + (m_hr % 10);
    cur_flags = 8'h00;
    check_all("R9 hours tens masked");

    // R10: tick colliding with a digit load
    cmd(8'h22);
    @(negedge clk);
    bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h07; tick_1s = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1s = 1'b0;
    m_min = (m_min / 10) * 10 + 7;
    model_advance();
    check_all("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule